// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector and Service Tracker

This block keeps interrupt bookkeeping for a pair of serial channels, A and B. Each channel has four flags: receive pending, transmit pending, receive in service and transmit in service. Single-cycle event strobes set and clear these flags. They come from the channel's data path: a byte arrived, the data port was read, the data port was written, a clear-transmit command, and a reset-in-service command. The block holds two shared registers. The first is a pending-bits register that reports which sources are raised. The second is an interrupt vector register that names the source most recently raised or lowered, and its encoding follows a per-channel status-high select. One combined interrupt request is formed from the pending flags, the per-channel enables and the break inputs.

Receive service takes precedence over transmit service. While a receive is in service, a transmit event only records that transmit is pending. The transmit is brought forward later, when the receive is read out or its in-service mark is reset. Strobes that arrive in the same cycle are applied one after another in a fixed order, so the shared vector register always ends up holding a single, well-defined code.

Top module: `sio_irq_vector`

## Requirements
- R1: After reset, irq is 0, pend_reg is 0 and vec_reg is 0x00, and all per-channel pending and in-service flags are clear.
- R2: irq is the OR over both channels of three terms: (tx_ie and transmit pending), (rx_mode equal to 01 or 10, and receive pending), and (brk_ie and brk_stat). rx_mode 00 and 11 block the receive term. irq responds combinationally to enable changes.
- R3: pend_reg bit 5 is receive A, bit 4 is transmit A, bit 2 is receive B and bit 1 is transmit B. Bits 0 and 3 (external sources) always read 0.
- R4: vec_reg codes with stat_hi of the acting channel clear: none 0x06, receive A 0x0C, receive B 0x04, transmit A 0x08, transmit B 0x00. With it set: none 0x60, receive A 0x30, receive B 0x20, transmit A 0x10, transmit B 0x00.
- R5: rx_evt sets receive pending and receive in service. It sets the channel's receive bit in pend_reg and loads the receive vector on the next clock.
- R6: wr_evt sets transmit pending. If receive is not in service, it also marks transmit in service, loads the transmit vector, and sets the transmit pend_reg bit when tx_ie is 1. If receive is in service, pend_reg and vec_reg are left unchanged.
- R7: rd_evt clears receive pending and receive in service, clears the receive pend_reg bit and loads the none vector. It then repeats the transmit raise of R6 if transmit is still pending.
- R8: clr_tx_cmd clears transmit pending and transmit in service, clears the transmit pend_reg bit and loads the none vector. It then repeats the receive raise of R5 if receive is still pending.
- R9: rst_ius_cmd clears receive in service if it is set, then repeats the transmit raise if transmit is pending. Otherwise it clears transmit in service and leaves pend_reg and vec_reg unchanged.
- R10: Strobes in one cycle are applied in this order: channel A before channel B, and within a channel rx_evt, rd_evt, wr_evt, clr_tx_cmd, rst_ius_cmd. A receive is therefore in service before a same-cycle write is considered.
- R11: The break term raises irq without touching pend_reg or vec_reg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_evt | input | 2 | Byte received strobe, bit 0 channel A, bit 1 channel B |
| rd_evt | input | 2 | Data-port read strobe per channel |
| wr_evt | input | 2 | Data-port write strobe per channel |
| clr_tx_cmd | input | 2 | Clear-transmit-pending command strobe per channel |
| rst_ius_cmd | input | 2 | Reset-in-service command strobe per channel |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| rx_mode | input | 4 | Receive interrupt mode, [1:0] channel A, [3:2] channel B |
| brk_ie | input | 2 | Break interrupt enable per channel |
| brk_stat | input | 2 | Break status per channel |
| stat_hi | input | 2 | Status-high vector encoding select per channel |
| irq | output | 1 | Combined interrupt request |
| pend_reg | output | 6 | Shared pending-bits register |
| vec_reg | output | 8 | Shared interrupt vector register |

## Verification
The vector and pending assertions assume a clocked property whose trigger is a cycle carrying a single strobe. They also assume stat_hi is a plain level, sampled in the cycle of that strobe. The stimulus changes strobes and levels only at the falling edge and mostly issues one strobe per cycle. It departs from this only in the scenarios that exercise same-cycle ordering, where the single-strobe assertions simply do not trigger. Enables and break levels are moved on their own between strobe cycles, so the combinational irq can be sampled after they settle.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  localparam int NCH    = 2;
  localparam int PEND_W = 6;
  localparam int VEC_W  = 8;
  localparam int MODE_W = 2;

  typedef struct packed {
    logic rx_pend;
    logic tx_pend;
    logic rx_svc;
    logic tx_svc;
  } chan_st_t;

  typedef struct packed {
    logic rx;
    logic rd;
    logic wr;
    logic clr_tx;
    logic rst_ius;
  } chan_ev_t;

  typedef struct packed {
    chan_st_t          st;
    logic [PEND_W-1:0] pend;
    logic [VEC_W-1:0]  vec;
  } step_t;

  typedef enum logic [1:0] {SRC_NONE, SRC_RX, SRC_TX} src_e;

  function automatic logic [VEC_W-1:0] vec_code(src_e src, logic chan_b, logic hi);
    logic [VEC_W-1:0] c;
    unique case (src)
      SRC_RX:  c = chan_b ? (hi ? 8'h20 : 8'h04) : (hi ? 8'h30 : 8'h0C);
      SRC_TX:  c = chan_b ? 8'h00 : (hi ? 8'h10 : 8'h08);
      default: c = hi ? 8'h60 : 8'h06;
    endcase
    return c;
  endfunction

  function automatic int rx_bit(logic chan_b);
    return chan_b ? 2 : 5;
  endfunction

  function automatic int tx_bit(logic chan_b);
    return chan_b ? 1 : 4;
  endfunction

  function automatic step_t raise_rx(step_t s, logic chan_b, logic hi);
    step_t r = s;
    r.st.rx_pend = 1'b1;
    r.st.rx_svc  = 1'b1;
    r.pend[rx_bit(chan_b)] = 1'b1;
    r.vec = vec_code(SRC_RX, chan_b, hi);
    return r;
  endfunction

  function automatic step_t raise_tx(step_t s, logic chan_b, logic ie, logic hi);
    step_t r = s;
    r.st.tx_pend = 1'b1;
    if (!r.st.rx_svc) begin
      r.st.tx_svc = 1'b1;
      if (ie) r.pend[tx_bit(chan_b)] = 1'b1;
      r.vec = vec_code(SRC_TX, chan_b, hi);
    end
    return r;
  endfunction

  function automatic step_t drop_rx(step_t s, logic chan_b, logic ie, logic hi);
    step_t r = s;
    r.st.rx_pend = 1'b0;
    r.st.rx_svc  = 1'b0;
    r.pend[rx_bit(chan_b)] = 1'b0;
    r.vec = vec_code(SRC_NONE, chan_b, hi);
    if (r.st.tx_pend) r = raise_tx(r, chan_b, ie, hi);
    return r;
  endfunction

  function automatic step_t drop_tx(step_t s, logic chan_b, logic hi);
    step_t r = s;
    r.st.tx_pend = 1'b0;
    r.st.tx_svc  = 1'b0;
    r.pend[tx_bit(chan_b)] = 1'b0;
    r.vec = vec_code(SRC_NONE, chan_b, hi);
    if (r.st.rx_pend) r = raise_rx(r, chan_b, hi);
    return r;
  endfunction

  function automatic step_t pop_svc(step_t s, logic chan_b, logic ie, logic hi);
    step_t r = s;
    if (r.st.rx_svc) begin
      r.st.rx_svc = 1'b0;
      if (r.st.tx_pend) r = raise_tx(r, chan_b, ie, hi);
    end else if (r.st.tx_svc) begin
      r.st.tx_svc = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/sio_irq_step.sv
module sio_irq_step
  import sio_irq_pkg::*;
#(
  parameter bit CHAN_B = 1'b0
) (
  input  chan_st_t          st_i,
  input  chan_ev_t          ev,
  input  logic              tx_ie,
  input  logic              hi,
  input  logic [PEND_W-1:0] pend_i,
  input  logic [VEC_W-1:0]  vec_i,
  output chan_st_t          st_o,
  output logic [PEND_W-1:0] pend_o,
  output logic [VEC_W-1:0]  vec_o
);

  step_t s;

  // Fixed application order: receive, read, write, clear-tx, reset-in-service.
  always_comb begin
    s = '{st: st_i, pend: pend_i, vec: vec_i};
    if (ev.rx)      s = raise_rx(s, CHAN_B, hi);
    if (ev.rd)      s = drop_rx(s, CHAN_B, tx_ie, hi);
    if (ev.wr)      s = raise_tx(s, CHAN_B, tx_ie, hi);
    if (ev.clr_tx)  s = drop_tx(s, CHAN_B, hi);
    if (ev.rst_ius) s = pop_svc(s, CHAN_B, tx_ie, hi);
  end

  assign st_o   = s.st;
  assign pend_o = s.pend;
  assign vec_o  = s.vec;

endmodule

// File: rtl/sio_irq_merge.sv
module sio_irq_merge
  import sio_irq_pkg::*;
(
  input  chan_st_t [NCH-1:0]        st,
  input  logic [NCH-1:0]            tx_ie,
  input  logic [NCH*MODE_W-1:0]     rx_mode,
  input  logic [NCH-1:0]            brk_ie,
  input  logic [NCH-1:0]            brk_stat,
  output logic                      irq
);

  logic [NCH-1:0] chan_req;

  for (genvar g = 0; g < NCH; g++) begin : g_term
    logic [MODE_W-1:0] mode;
    logic              rx_on;
    assign mode  = rx_mode[g*MODE_W +: MODE_W];
    assign rx_on = (mode == 2'b01) || (mode == 2'b10);
    assign chan_req[g] = (tx_ie[g] & st[g].tx_pend)
                       | (rx_on & st[g].rx_pend)
                       | (brk_ie[g] & brk_stat[g]);
  end

  assign irq = |chan_req;

endmodule

// File: rtl/sio_irq_vector.sv
module sio_irq_vector
  import sio_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  rx_evt,
  input  logic [1:0]  rd_evt,
  input  logic [1:0]  wr_evt,
  input  logic [1:0]  clr_tx_cmd,
  input  logic [1:0]  rst_ius_cmd,
  input  logic [1:0]  tx_ie,
  input  logic [3:0]  rx_mode,
  input  logic [1:0]  brk_ie,
  input  logic [1:0]  brk_stat,
  input  logic [1:0]  stat_hi,
  output logic        irq,
  output logic [5:0]  pend_reg,
  output logic [7:0]  vec_reg
);

  chan_st_t [NCH-1:0] st_q, st_d;
  logic [PEND_W-1:0]  pend_q;
  logic [VEC_W-1:0]   vec_q;

  // Shared registers thread through the channels, A first, then B.
  logic [PEND_W-1:0]  pend_chain [NCH+1];
  logic [VEC_W-1:0]   vec_chain  [NCH+1];

  assign pend_chain[0] = pend_q;
  assign vec_chain[0]  = vec_q;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    chan_ev_t ev;
    assign ev = '{rx: rx_evt[g], rd: rd_evt[g], wr: wr_evt[g],
                  clr_tx: clr_tx_cmd[g], rst_ius: rst_ius_cmd[g]};
    sio_irq_step #(.CHAN_B(g == 1)) u_step (
      .st_i   (st_q[g]),
      .ev     (ev),
      .tx_ie  (tx_ie[g]),
      .hi     (stat_hi[g]),
      .pend_i (pend_chain[g]),
      .vec_i  (vec_chain[g]),
      .st_o   (st_d[g]),
      .pend_o (pend_chain[g+1]),
      .vec_o  (vec_chain[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= '0;
      pend_q <= '0;
      vec_q  <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_chain[NCH];
      vec_q  <= vec_chain[NCH];
    end
  end

  sio_irq_merge u_merge (
    .st       (st_q),
    .tx_ie    (tx_ie),
    .rx_mode  (rx_mode),
    .brk_ie   (brk_ie),
    .brk_stat (brk_stat),
    .irq      (irq)
  );

  assign pend_reg = pend_q;
  assign vec_reg  = vec_q;

endmodule

// File: rtl/sio_irq_vector_chk.sv
module sio_irq_vector_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  rx_evt,
  input logic [1:0]  rd_evt,
  input logic [1:0]  wr_evt,
  input logic [1:0]  clr_tx_cmd,
  input logic [1:0]  rst_ius_cmd,
  input logic [1:0]  tx_ie,
  input logic [3:0]  rx_mode,
  input logic [1:0]  brk_ie,
  input logic [1:0]  brk_stat,
  input logic [1:0]  stat_hi,
  input logic        irq,
  input logic [5:0]  pend_reg,
  input logic [7:0]  vec_reg
);

  logic quiet_other;
  assign quiet_other = (wr_evt == 2'b00) && (clr_tx_cmd == 2'b00) && (rst_ius_cmd == 2'b00);

  assert_ext_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_reg[0] && !pend_reg[3]);

  assert_vec_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_reg inside {8'h00, 8'h04, 8'h06, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h30, 8'h60});

  assert_rx_a_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt == 2'b01 && rd_evt == 2'b00 && quiet_other)
    |=> pend_reg[5] && vec_reg == ($past(stat_hi[0]) ? 8'h30 : 8'h0C));

  assert_rx_b_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt == 2'b10 && rd_evt == 2'b00 && quiet_other)
    |=> pend_reg[2] && vec_reg == ($past(stat_hi[1]) ? 8'h20 : 8'h04));

  assert_read_a_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt == 2'b01 && rx_evt == 2'b00 && quiet_other) |=> !pend_reg[5]);

  assert_quiet_when_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ie == 2'b00 && rx_mode == 4'b0000 && brk_ie == 2'b00) |-> !irq);

  assert_break_raises_R11: assert property (@(posedge clk) disable iff (!rst_n)
    |(brk_ie & brk_stat) |-> irq);

endmodule

bind sio_irq_vector sio_irq_vector_chk u_chk (.*);

// File: tb/sio_irq_vector_bench.sv
`timescale 1ns/1ps
module sio_irq_vector_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] rx_evt, rd_evt, wr_evt, clr_tx_cmd, rst_ius_cmd;
  logic [1:0] tx_ie, brk_ie, brk_stat, stat_hi;
  logic [3:0] rx_mode;
  logic       irq;
  logic [5:0] pend_reg;
  logic [7:0] vec_reg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sio_irq_vector u_sio_irq_vector (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic outs(string tag, logic i, logic [5:0] p, logic [7:0] v);
    chk({tag, " irq"}, {7'd0, irq}, {7'd0, i});
    chk({tag, " pend"}, {2'd0, pend_reg}, {2'd0, p});
    chk({tag, " vec"}, vec_reg, v);
  endtask

  // Drive one cycle of strobes at the falling edge, release at the next one.
  task automatic ev(logic [1:0] rx, logic [1:0] rd, logic [1:0] wr,
                    logic [1:0] ct, logic [1:0] ri);
    @(negedge clk);
    rx_evt = rx; rd_evt = rd; wr_evt = wr; clr_tx_cmd = ct; rst_ius_cmd = ri;
    @(negedge clk);
    rx_evt = '0; rd_evt = '0; wr_evt = '0; clr_tx_cmd = '0; rst_ius_cmd = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    outs("R1 reset", 1'b0, 6'h00, 8'h00);
  endtask

  task automatic t_rx_path();
    ev(2'b01, 0, 0, 0, 0); outs("R5 rxA lo", 1'b1, 6'h20, 8'h0C);
    ev(0, 2'b01, 0, 0, 0); outs("R7 rdA", 1'b0, 6'h00, 8'h06);
    stat_hi = 2'b10;
    ev(2'b10, 0, 0, 0, 0); outs("R4 rxB hi", 1'b1, 6'h04, 8'h20);
    ev(0, 2'b10, 0, 0, 0); outs("R4 rdB hi none", 1'b0, 6'h00, 8'h60);
    stat_hi = 2'b00;
  endtask

  task automatic t_tx_path();
    ev(0, 0, 2'b01, 0, 0); outs("R6 wrA", 1'b1, 6'h10, 8'h08);
    ev(0, 0, 0, 2'b01, 0); outs("R8 clrA", 1'b0, 6'h00, 8'h06);
    @(negedge clk); tx_ie = 2'b10;
    ev(0, 0, 2'b01, 0, 0); outs("R6 wrA masked", 1'b0, 6'h00, 8'h08);
    @(negedge clk); tx_ie = 2'b11; #1;
    chk("R2 late enable irq", {7'd0, irq}, 8'h01);
    ev(0, 0, 0, 2'b01, 0); outs("R8 clrA after", 1'b0, 6'h00, 8'h06);
    stat_hi = 2'b10;
    ev(0, 0, 2'b10, 0, 0); outs("R4 wrB hi", 1'b1, 6'h02, 8'h00);
    ev(0, 0, 0, 2'b10, 0); outs("R8 clrB hi", 1'b0, 6'h00, 8'h60);
    stat_hi = 2'b00;
  endtask

  task automatic t_priority();
    ev(2'b01, 0, 0, 0, 0);
    ev(0, 0, 2'b01, 0, 0); outs("R6 wr under rx", 1'b1, 6'h20, 8'h0C);
    ev(0, 0, 0, 0, 2'b01); outs("R9 ius pops rx", 1'b1, 6'h30, 8'h08);
    ev(0, 2'b01, 0, 0, 0); outs("R7 rd reraises tx", 1'b1, 6'h10, 8'h08);
    ev(0, 0, 0, 2'b01, 0); outs("R8 clr idle", 1'b0, 6'h00, 8'h06);
  endtask

  task automatic t_ius_tx();
    ev(0, 0, 2'b01, 0, 0);
    ev(0, 0, 0, 0, 2'b01); outs("R9 ius tx only", 1'b1, 6'h10, 8'h08);
    ev(0, 0, 0, 2'b01, 0); outs("R9 cleanup", 1'b0, 6'h00, 8'h06);
  endtask

  task automatic t_clr_reraise();
    ev(2'b01, 0, 0, 0, 0);
    ev(0, 0, 2'b01, 0, 0);
    ev(0, 0, 0, 0, 2'b01);
    ev(0, 0, 0, 2'b01, 0); outs("R8 clr reraises rx", 1'b1, 6'h20, 8'h0C);
    ev(0, 2'b01, 0, 0, 0); outs("R7 rd final", 1'b0, 6'h00, 8'h06);
  endtask

  task automatic t_ordering();
    ev(2'b01, 0, 2'b01, 0, 0); outs("R10 rx before wr", 1'b1, 6'h20, 8'h0C);
    ev(0, 2'b01, 0, 0, 0); outs("R10 rd then tx", 1'b1, 6'h10, 8'h08);
    ev(0, 0, 0, 2'b01, 0);
    ev(2'b11, 0, 0, 0, 0); outs("R10 A before B", 1'b1, 6'h24, 8'h04);
    ev(0, 2'b11, 0, 0, 0); outs("R10 both read", 1'b0, 6'h00, 8'h06);
  endtask

  task automatic t_irq_terms();
    @(negedge clk); brk_ie = 2'b01; brk_stat = 2'b01; #1;
    chk("R11 break irq", {7'd0, irq}, 8'h01);
    chk("R11 break pend", {2'd0, pend_reg}, 8'h00);
    @(negedge clk); brk_ie = 2'b00; #1;
    chk("R2 break masked", {7'd0, irq}, 8'h00);
    @(negedge clk); brk_stat = 2'b00; rx_mode = 4'b1101;
    ev(2'b10, 0, 0, 0, 0); outs("R2 mode 11 blocks", 1'b0, 6'h04, 8'h04);
    @(negedge clk); rx_mode = 4'b1001; #1;
    chk("R2 mode 10 passes", {7'd0, irq}, 8'h01);
    ev(0, 2'b10, 0, 0, 0); outs("R7 rdB", 1'b0, 6'h00, 8'h06);
    ev(2'b01, 0, 2'b10, 0, 0);
    do_reset(); #1;
    outs("R1 reset mid-run", 1'b0, 6'h00, 8'h00);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    rst_n = 1'b0;
    rx_evt = '0; rd_evt = '0; wr_evt = '0; clr_tx_cmd = '0; rst_ius_cmd = '0;
    tx_ie = 2'b11; rx_mode = 4'b0101; brk_ie = '0; brk_stat = '0; stat_hi = '0;
    t_reset();
    t_rx_path();
    t_tx_path();
    t_priority();
    t_ius_tx();
    t_clr_reraise();
    t_ordering();
    t_irq_terms();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

endmodule